// File: doc/BRIEF.md
# Serial Configuration Write Receiver

This block takes configuration write commands that arrive one bit at a time and applies them to a bank of sixteen byte-wide registers. The bit stream has already been recovered from the line. Each bit comes as a one-cycle valid strobe with a bit value. The receiver aligns on two fixed start bits and assembles an 18-bit command. It checks the command code and the even parity, then writes the data byte to the addressed register.

An accepted write gives a one-cycle acknowledge pulse together with the address that was written. A malformed command gives a one-cycle error pulse instead. A lock input freezes the register bank: while it is high, well-formed writes are dropped without any response. If the line goes quiet mid-frame for longer than a programmable number of cycles, the partial command is abandoned, so the next bit is taken as a fresh start bit. Every register is visible at all times on a flattened output bus.

Top module: `cfg_wr_rx`

## Requirements
- R1: After reset every register reads 0x00 on `reg_q_o`, and `ack_o` and `err_o` are low.
- R2: A well-formed frame writes its data byte into the addressed register. One cycle after the strobe of its final bit, `ack_o` pulses for one cycle with `ack_addr_o` equal to the address, and `reg_q_o` shows the new byte in that same cycle.
- R3: Frame bits arrive least significant first. In arrival order they are: position 0 start bit (1), position 1 start bit (0), positions 2 to 5 the address, positions 6 to 13 the data, positions 14 to 16 the command code, and position 17 parity. Each field is sent LSB first.
- R4: When the count of ones over all 18 bits is odd, `err_o` pulses one cycle after the final bit and no register changes.
- R5: When the command code is any value other than 3'b001, `err_o` pulses one cycle after the final bit and no register changes.
- R6: When the first bit is 0, or the second bit is 1, `err_o` pulses one cycle after that bit and the frame is dropped. The next bit is then treated as the first start bit.
- R7: A gap of more than `gap_lim_i` idle cycles between two bits of one frame resets the bit position without an error pulse. A gap of exactly `gap_lim_i` cycles keeps the frame going.
- R8: While `lock_i` is high at the final bit of a well-formed frame, that frame has no effect: no register changes, and neither `ack_o` nor `err_o` pulses.
- R9: `ack_o` and `err_o` never pulse in the same cycle, `ack_o` never lasts more than one cycle, and `reg_q_o` changes only in a cycle where `ack_o` is high.
- R10: Each of the 16 addresses selects its own register. Register n occupies bits [8n+7:8n] of `reg_q_o`, and a write leaves the other fifteen registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | One-cycle strobe marking a received bit |
| bit_val_i | input | 1 | Value of the received bit |
| lock_i | input | 1 | When high, well-formed writes are dropped silently |
| gap_lim_i | input | GAP_W | Largest idle gap, in cycles, allowed between bits of one frame |
| ack_o | output | 1 | One-cycle pulse for an accepted write |
| ack_addr_o | output | 4 | Address of the last accepted write |
| err_o | output | 1 | One-cycle pulse for a rejected frame |
| reg_q_o | output | 128 | All sixteen registers, register n at bits [8n+7:8n] |

## Verification
The hardest situation to reach from the ports is a stale partial frame. A few bits of one command are followed by a gap just one cycle longer than the limit, and then a complete command arrives. If the timeout were missed, the new bits would land at the wrong positions and show up as an error rather than an acknowledge. The bench builds this directly. It also sends complete frames whose bits are spaced exactly at the limit, so both sides of the boundary are covered. Random frames mix good writes, parity flips, wrong command codes and locked writes across every address, with random spacing up to the limit.

// File: rtl/cfg_wr_pkg.sv
package cfg_wr_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int CMD_W     = 3;
  localparam logic [CMD_W-1:0] CMD_WRITE = 3'b001;
  localparam int ADDR_LSB  = 2;
  localparam int DATA_LSB  = ADDR_LSB + ADDR_W;
  localparam int CMD_LSB   = DATA_LSB + DATA_W;
  localparam int PAR_POS   = CMD_LSB + CMD_W;
  localparam int FRAME_LEN = PAR_POS + 1;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int NREG      = 1 << ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/cfg_gap_timer.sv
module cfg_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             bit_vld_i,
  input  logic [GAP_W-1:0] lim_i,
  output logic             timeout_o
);
  logic [GAP_W-1:0] idle_q, idle_d;

  assign timeout_o = busy_i & ~bit_vld_i & (idle_q == lim_i);

  always_comb begin
    if (!busy_i || bit_vld_i || timeout_o) idle_d = '0;
    else                                   idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= '0;
    else         idle_q <= idle_d;
  end
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_wr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    bit_vld_i,
  input  logic    bit_val_i,
  input  logic    abort_i,
  output logic    busy_o,
  output logic    fin_o,
  output logic    good_o,
  output logic    start_err_o,
  output wr_req_t req_o
);
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_LEN-1:0] sh_q;
  logic [FRAME_LEN-1:0] full;
  logic                 at_first, at_second, at_last;

  assign at_first  = (cnt_q == CNT_W'(0));
  assign at_second = (cnt_q == CNT_W'(1));
  assign at_last   = (cnt_q == CNT_W'(FRAME_LEN - 1));

  // frame as it stands once the current bit is included, index = arrival position
  assign full = {bit_val_i, sh_q[FRAME_LEN-1:1]};

  assign busy_o      = ~at_first;
  assign fin_o       = bit_vld_i & at_last;
  assign start_err_o = bit_vld_i & ((at_first & ~bit_val_i) | (at_second & bit_val_i));
  assign good_o      = ~(^full) & (full[CMD_LSB +: CMD_W] == CMD_WRITE);
  assign req_o.addr  = full[ADDR_LSB +: ADDR_W];
  assign req_o.data  = full[DATA_LSB +: DATA_W];

  always_comb begin
    cnt_d = cnt_q;
    if (abort_i) begin
      cnt_d = '0;
    end else if (bit_vld_i) begin
      if (start_err_o || at_last) cnt_d = '0;
      else                        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (bit_vld_i) sh_q <= full;
    end
  end
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_wr_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  wr_req_t                req_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     q <= '0;
      else if (we_i && (req_i.addr == ADDR_W'(g)))     q <= req_i.data;
    end
    assign regs_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/cfg_wr_rx.sv
module cfg_wr_rx
  import cfg_wr_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bit_vld_i,
  input  logic                   bit_val_i,
  input  logic                   lock_i,
  input  logic [GAP_W-1:0]       gap_lim_i,
  output logic                   ack_o,
  output logic [ADDR_W-1:0]      ack_addr_o,
  output logic                   err_o,
  output logic [NREG*DATA_W-1:0] reg_q_o
);
  logic    busy, timeout, fin, good, start_err, we;
  wr_req_t req;

  cfg_gap_timer #(.GAP_W(GAP_W)) gap_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .bit_vld_i (bit_vld_i),
    .lim_i     (gap_lim_i),
    .timeout_o (timeout)
  );

  cfg_frame_rx frm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_vld_i   (bit_vld_i),
    .bit_val_i   (bit_val_i),
    .abort_i     (timeout),
    .busy_o      (busy),
    .fin_o       (fin),
    .good_o      (good),
    .start_err_o (start_err),
    .req_o       (req)
  );

  // locked writes vanish: no write, no ack, no error
  assign we = fin & good & ~lock_i;

  cfg_reg_file rf_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .req_i  (req),
    .regs_o (reg_q_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o      <= 1'b0;
      ack_addr_o <= '0;
      err_o      <= 1'b0;
    end else begin
      ack_o <= we;
      err_o <= start_err | (fin & ~good);
      if (we) ack_addr_o <= req.addr;
    end
  end
endmodule

// File: rtl/cfg_wr_rx_chk.sv
module cfg_wr_rx_chk
  import cfg_wr_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lock_i,
  input logic                   ack_o,
  input logic                   err_o,
  input logic [NREG*DATA_W-1:0] reg_q_o
);
  a_r9_ack_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !err_o);

  a_r9_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r9_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> $stable(reg_q_o));

  a_r8_lock_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> !ack_o);
endmodule

bind cfg_wr_rx cfg_wr_rx_chk #(.GAP_W(GAP_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .lock_i  (lock_i),
  .ack_o   (ack_o),
  .err_o   (err_o),
  .reg_q_o (reg_q_o)
);

// File: tb/cfg_wr_rx_tb_top.sv
module cfg_wr_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_W      = 8;
  localparam int NREG       = 16;
  localparam int DW         = 8;
  localparam int FLEN       = 18;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             vld = 1'b0, bv = 1'b0, lock = 1'b0;
  logic [GAP_W-1:0] gap_lim = 8'd3;
  logic             ack, err;
  logic [3:0]       ack_addr;
  logic [NREG*DW-1:0] regs;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [NREG];

  cfg_wr_rx #(.GAP_W(GAP_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_vld_i(vld), .bit_val_i(bv), .lock_i(lock),
    .gap_lim_i(gap_lim), .ack_o(ack), .ack_addr_o(ack_addr), .err_o(err), .reg_q_o(regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [NREG*DW-1:0] act, input logic [NREG*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NREG*DW-1:0] model_flat();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = model[i];
    return v;
  endfunction

  // R3: arrival-order layout
  function automatic logic [FLEN-1:0] mk_frame(input logic [3:0] a, input logic [7:0] d,
                                               input logic [2:0] c, input logic flip);
    logic [FLEN-1:0] f;
    f[0] = 1'b1; f[1] = 1'b0; f[5:2] = a; f[13:6] = d; f[16:14] = c;
    f[17] = (^f[16:0]) ^ flip;
    return f;
  endfunction

  // entered and left on a falling edge; gap = idle cycles after the bit
  task automatic send_bit(input logic b, input int gap);
    vld = 1'b1; bv = b;
    @(negedge clk);
    vld = 1'b0; bv = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_frame(input logic [3:0] a, input logic [7:0] d, input logic [2:0] c,
                           input logic flip, input logic lk, input int gap, input string req);
    logic [FLEN-1:0] f;
    logic ok;
    f = mk_frame(a, d, c, flip);
    lock = lk;
    for (int i = 0; i < FLEN; i++) send_bit(f[i], (i == FLEN-1) ? 0 : gap);
    ok = (c == 3'b001) && !flip;
    check({req, " ack"}, ack, ok && !lk);
    check({req, " err"}, err, !ok);
    if (ok && !lk) begin
      check({req, " ack_addr"}, ack_addr, a);
      model[a] = d;
    end
    check({req, " regs"}, regs, model_flat());
    lock = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 regs", regs, '0);
    check("R1 ack", ack, 1'b0);
    check("R1 err", err, 1'b0);

    run_frame(4'h0, 8'hA5, 3'b001, 1'b0, 1'b0, 0, "R2 basic write");
    run_frame(4'h1, 8'h3C, 3'b001, 1'b0, 1'b0, 2, "R3 spaced write");
    for (int a = 0; a < NREG; a++)
      run_frame(4'(a), 8'(8'h11 * a + 8'h07), 3'b001, 1'b0, 1'b0, 0, "R10 address sweep");
    run_frame(4'h5, 8'hFF, 3'b001, 1'b1, 1'b0, 0, "R4 odd parity");
    run_frame(4'h6, 8'h00, 3'b011, 1'b0, 1'b0, 1, "R5 bad command");
    run_frame(4'h7, 8'h55, 3'b000, 1'b0, 1'b0, 0, "R5 zero command");
    run_frame(4'h8, 8'h99, 3'b001, 1'b0, 1'b1, 0, "R8 locked write");

    // R6: wrong first bit, then wrong second bit, then a clean frame realigns
    send_bit(1'b0, 0);
    check("R6 first start err", err, 1'b1);
    check("R6 first start regs", regs, model_flat());
    send_bit(1'b1, 0);
    send_bit(1'b1, 0);
    check("R6 second start err", err, 1'b1);
    run_frame(4'h9, 8'h6B, 3'b001, 1'b0, 1'b0, 0, "R6 realign");

    // R7: stale partial frame dropped after gap_lim+1 idle cycles
    for (int i = 0; i < 5; i++) send_bit(mk_frame(4'h2, 8'hEE, 3'b001, 1'b0)[i], 0);
    for (int i = 0; i < int'(gap_lim) + 1; i++) begin
      check("R7 no err on timeout", err, 1'b0);
      @(negedge clk);
    end
    run_frame(4'hA, 8'hC3, 3'b001, 1'b0, 1'b0, 0, "R7 after timeout");
    run_frame(4'hB, 8'h1E, 3'b001, 1'b0, 1'b0, int'(gap_lim), "R7 gap at limit");

    // random mix
    for (int n = 0; n < 250; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic [2:0] c;
      int kind;
      a = 4'($urandom); d = 8'($urandom); kind = int'($urandom % 4);
      c = 3'b001;
      if (kind == 2) begin
        c = 3'($urandom);
        if (c == 3'b001) c = 3'b101;
      end
      run_frame(a, d, c, kind == 1, kind == 3, int'($urandom % (int'(gap_lim) + 1)),
                "R2 R4 R5 R8 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule